// File: doc/BRIEF.md
# Nibble Pair to Byte Joiner

This block sits between a narrow sender and a wider receiver. The sender delivers a byte as two separate half-width transfers. Each transfer is a nibble on `nib_i` qualified by a pulse on `nib_vld_i`, with the low half sent first and the high half second. Once both halves are held, the block presents the joined byte on `byte_o` and raises `byte_vld_o` for one clock cycle.

A controller steps through a fixed sequence and drives three load strobes into a small datapath. The datapath holds a low-half register, a high-half register and the output byte register. Each nibble is accepted through a pair of states. The first state records the capture. The second waits until the qualifier drops, so a qualifier held high for several cycles counts as one transfer. The byte is sent through another pair of states that frames a single strobe cycle and then returns to idle.

The nibble width is a parameter. A second parameter selects whether the output strobe comes from its own flop or is decoded from the state register.

Top module: `nib_pair_join`

## Requirements
- R1: While `rst_ni` is low, `byte_o` is 0 and `byte_vld_o` is 0. After reset the block waits for a low nibble, and any half captured before the reset is discarded.
- R2: The low nibble is the value on `nib_i` at the first rising clock edge where `nib_vld_i` is high while the block waits for a low half.
- R3: After the low stage completes, the high nibble is the value on `nib_i` at the first rising edge where `nib_vld_i` is high while the block waits for a high half.
- R4: After each capture the block takes no further nibble until `nib_vld_i` has been sampled low. A level held high for several cycles is one transfer, and changes on `nib_i` during that hold have no effect.
- R5: The joined byte carries the high nibble in bits [2*NIB_W-1:NIB_W] and the low nibble in bits [NIB_W-1:0].
- R6: `byte_vld_o` is high for exactly one cycle per joined byte. It rises at the first edge where `nib_vld_i` is sampled low after the high capture, and never earlier than two edges after that capture. `byte_o` shows the new byte in that same cycle.
- R7: A single nibble never produces a `byte_vld_o` pulse.
- R8: `byte_o` keeps its value after `byte_vld_o` falls, until the next joined byte is loaded.
- R9: Two cycles after `byte_vld_o` rises, the block again waits for a low nibble, so bytes can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_i | input | NIB_W | Nibble from the sender |
| nib_vld_i | input | 1 | Qualifier pulse for `nib_i` |
| byte_o | output | 2*NIB_W | Joined byte |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte |

## Verification
The bench targets qualifiers held high for several cycles while `nib_i` changes underneath. A design that recaptured on a held level would either emit a byte after one slow transfer or fold the changed value into the result. It also checks the exact strobe cycle after a one-cycle high pulse and the half ordering within the byte. A design with an extra register stage, or with the halves swapped, gives the wrong byte or a late strobe. A reset in the middle of a pair, minimum-gap sequences and a check that `byte_o` holds after the strobe catch designs that keep stale halves, lose the ready state between bytes, or clear the output early.

// File: rtl/nbj_pkg.sv
`timescale 1ns/1ps
package nbj_pkg;

   // Number of half-width transfers per output word; the sequencing is
   // written for exactly this count.
   localparam int NUM_HALF = 2;

   typedef enum logic [2:0] {
      ST_WAIT_LO = 3'd0,
      ST_CAP_LO  = 3'd1,
      ST_HOLD_LO = 3'd2,
      ST_WAIT_HI = 3'd3,
      ST_CAP_HI  = 3'd4,
      ST_HOLD_HI = 3'd5,
      ST_EMIT    = 3'd6,
      ST_DONE    = 3'd7
   } join_st_e;

endpackage

// File: rtl/nbj_ctrl.sv
`timescale 1ns/1ps
module nbj_ctrl
   import nbj_pkg::*;
#(
   parameter bit VLD_FLOP = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                nib_vld_i,
   output logic [NUM_HALF-1:0] ld_half_o,
   output logic                ld_byte_o,
   output logic                byte_vld_o
);

   join_st_e state_q, state_d;

   // Next-state decode
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WAIT_LO: if (nib_vld_i)  state_d = ST_CAP_LO;
         ST_CAP_LO:                  state_d = ST_HOLD_LO;
         ST_HOLD_LO: if (!nib_vld_i) state_d = ST_WAIT_HI;
         ST_WAIT_HI: if (nib_vld_i)  state_d = ST_CAP_HI;
         ST_CAP_HI:                  state_d = ST_HOLD_HI;
         ST_HOLD_HI: if (!nib_vld_i) state_d = ST_EMIT;
         ST_EMIT:                    state_d = ST_DONE;
         ST_DONE:                    state_d = ST_WAIT_LO;
         default:                    state_d = ST_WAIT_LO;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_WAIT_LO;
      else         state_q <= state_d;
   end

   // Load strobes fire on the edge that leaves a waiting state, so the
   // nibble is taken in the same cycle the qualifier is seen.
   assign ld_half_o[0] = (state_q == ST_WAIT_LO) && nib_vld_i;
   assign ld_half_o[1] = (state_q == ST_WAIT_HI) && nib_vld_i;
   assign ld_byte_o    = (state_q == ST_HOLD_HI) && !nib_vld_i;

   // Output strobe variant
   if (VLD_FLOP) begin : g_vld_flop
      logic vld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) vld_q <= 1'b0;
         else         vld_q <= (state_d == ST_EMIT) && (state_q != ST_EMIT);
      end
      assign byte_vld_o = vld_q;
   end else begin : g_vld_decode
      assign byte_vld_o = (state_q == ST_EMIT);
   end

   AST_VLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_vld_o |=> !byte_vld_o); // R6

   AST_HOLD_LO_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOLD_LO && nib_vld_i) |=> (state_q == ST_HOLD_LO)); // R4

   AST_HOLD_HI_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOLD_HI && nib_vld_i) |=> (state_q == ST_HOLD_HI)); // R4

   AST_EMIT_AFTER_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(byte_vld_o) |-> ($past(state_q) == ST_HOLD_HI)); // R7

   AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ld_half_o, ld_byte_o})); // R4

endmodule

// File: rtl/nbj_datapath.sv
`timescale 1ns/1ps
module nbj_datapath
   import nbj_pkg::*;
#(
   parameter  int NIB_W  = 4,
   localparam int BYTE_W = NUM_HALF * NIB_W
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NIB_W-1:0]               nib_i,
   input  logic [NUM_HALF-1:0]            ld_half_i,
   input  logic                           ld_byte_i,
   output logic [NUM_HALF-1:0][NIB_W-1:0] half_o,
   output logic [BYTE_W-1:0]              byte_o
);

   // One holding register per half; index 0 is the low half.
   for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          half_o[h] <= '0;
         else if (ld_half_i[h]) half_o[h] <= nib_i;
      end
   end

   // Packed array places index 1 (high half) in the upper bits.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_o <= '0;
      else if (ld_byte_i) byte_o <= half_o;
   end

   AST_BYTE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_byte_i |=> $stable(byte_o)); // R8

endmodule

// File: rtl/nib_pair_join.sv
`timescale 1ns/1ps
module nib_pair_join
   import nbj_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter bit VLD_FLOP = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NIB_W-1:0]          nib_i,
   input  logic                      nib_vld_i,
   output logic [NUM_HALF*NIB_W-1:0] byte_o,
   output logic                      byte_vld_o
);

   localparam int BYTE_W = NUM_HALF * NIB_W;

   if (NIB_W < 1) begin : g_bad_width
      $error("nib_pair_join: NIB_W must be at least 1");
   end

   logic [NUM_HALF-1:0]            ld_half;
   logic                           ld_byte;
   logic [NUM_HALF-1:0][NIB_W-1:0] half_q;
   logic [BYTE_W-1:0]              byte_q;

   nbj_ctrl #(
      .VLD_FLOP (VLD_FLOP)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .nib_vld_i  (nib_vld_i),
      .ld_half_o  (ld_half),
      .ld_byte_o  (ld_byte),
      .byte_vld_o (byte_vld_o)
   );

   nbj_datapath #(
      .NIB_W (NIB_W)
   ) u_dp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nib_i     (nib_i),
      .ld_half_i (ld_half),
      .ld_byte_i (ld_byte),
      .half_o    (half_q),
      .byte_o    (byte_q)
   );

   assign byte_o = byte_q;

   AST_BYTE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_vld_o |-> (byte_o == {half_q[1], half_q[0]})); // R5

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      !rst_ni |-> (byte_o == '0 && !byte_vld_o)); // R1

endmodule

// File: tb/nib_pair_join_bench.sv
`timescale 1ns/1ps
module nib_pair_join_bench;

   localparam int NW = 4;
   localparam int BW = 2 * NW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] nib = '0;
   logic          vld = 1'b0;
   logic [BW-1:0] byte_o;
   logic          byte_vld;

   int checks = 0;
   int fails  = 0;
   int vld_cycles = 0;
   logic [BW-1:0] last_byte = '0;
   bit finished = 0;

   always #2 clk = ~clk;

   nib_pair_join #(.NIB_W(NW)) u_nib_pair_join (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .nib_i      (nib),
      .nib_vld_i  (vld),
      .byte_o     (byte_o),
      .byte_vld_o (byte_vld)
   );

   always @(negedge clk) begin
      if (rst_n && byte_vld) begin
         vld_cycles++;
         last_byte = byte_o;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Drives one nibble; qualifier stays high for 'hold' edges, with nib
   // altered after the first edge so a recapture would show.
   task automatic send_nib(input logic [NW-1:0] n, input int hold);
      @(negedge clk); nib = n; vld = 1'b1;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk); nib = ~n;
      end
      vld = 1'b0;
   endtask

   typedef struct packed {
      logic [NW-1:0] lo;
      logic [NW-1:0] hi;
      logic [3:0]    hold_lo;
      logic [3:0]    hold_hi;
      logic [3:0]    gap;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{lo: 4'h5, hi: 4'hA, hold_lo: 4'd1, hold_hi: 4'd1, gap: 4'd2},
      '{lo: 4'hF, hi: 4'h0, hold_lo: 4'd3, hold_hi: 4'd1, gap: 4'd2},
      '{lo: 4'h0, hi: 4'hF, hold_lo: 4'd1, hold_hi: 4'd4, gap: 4'd3},
      '{lo: 4'hC, hi: 4'h3, hold_lo: 4'd2, hold_hi: 4'd2, gap: 4'd2},
      '{lo: 4'h0, hi: 4'h0, hold_lo: 4'd1, hold_hi: 4'd1, gap: 4'd5},
      '{lo: 4'h9, hi: 4'h6, hold_lo: 4'd5, hold_hi: 4'd5, gap: 4'd2}
   };

   initial begin
      #(4 * 100000);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      check(byte_o == '0, "R1 reset byte", byte_o, 0);
      check(byte_vld == 1'b0, "R1 reset strobe", byte_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table of vectors, sent back to back (R9)
      foreach (VECS[k]) begin
         base = vld_cycles;
         send_nib(VECS[k].lo, int'(VECS[k].hold_lo));
         repeat (int'(VECS[k].gap)) @(negedge clk);
         check(vld_cycles == base, "R7 no byte after one nibble", vld_cycles, base);
         send_nib(VECS[k].hi, int'(VECS[k].hold_hi));
         repeat (4) @(negedge clk);
         check(vld_cycles == base + 1, "R6/R4 one strobe per pair", vld_cycles, base + 1);
         check(last_byte == {VECS[k].hi, VECS[k].lo}, "R2/R3/R5/R9 joined byte",
               last_byte, {VECS[k].hi, VECS[k].lo});
         check(byte_o == {VECS[k].hi, VECS[k].lo}, "R8 byte held after strobe",
               byte_o, {VECS[k].hi, VECS[k].lo});
      end

      // Exact strobe timing after one-cycle pulses (R6)
      send_nib(4'h2, 1);
      repeat (2) @(negedge clk);
      send_nib(4'h7, 1);
      @(negedge clk);
      check(byte_vld == 1'b0, "R6 strobe not early", byte_vld, 0);
      @(negedge clk);
      check(byte_vld == 1'b1, "R6 strobe cycle", byte_vld, 1);
      check(byte_o == 8'h72, "R6 byte with strobe", byte_o, 8'h72);
      @(negedge clk);
      check(byte_vld == 1'b0, "R6 strobe one cycle", byte_vld, 0);
      check(byte_o == 8'h72, "R8 byte holds", byte_o, 8'h72);
      repeat (3) @(negedge clk);

      // Held high nibble: no strobe until the qualifier drops (R4)
      send_nib(4'h1, 1);
      repeat (2) @(negedge clk);
      @(negedge clk); nib = 4'hB; vld = 1'b1;
      base = vld_cycles;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); nib = 4'h4;
      end
      check(vld_cycles == base, "R4 no strobe while held", vld_cycles, base);
      vld = 1'b0;
      repeat (4) @(negedge clk);
      check(last_byte == 8'hB1, "R4 held level single capture", last_byte, 8'hB1);

      // Reset in the middle of a pair (R1)
      send_nib(4'hE, 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(byte_o == '0, "R1 byte cleared by reset", byte_o, 0);
      check(byte_vld == 1'b0, "R1 strobe low in reset", byte_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      send_nib(4'h8, 1);
      repeat (2) @(negedge clk);
      send_nib(4'hD, 1);
      repeat (4) @(negedge clk);
      check(last_byte == 8'hD8, "R1 stale half dropped", last_byte, 8'hD8);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule